// File: doc/BRIEF.md
# Rate-1/3 Parallel Concatenated Convolutional Encoder

This block turns a block of K information bits into a rate-1/3 turbo-coded stream. Bits arrive one per cycle over a valid/ready handshake, with a start-of-block marker on the first bit. They are held in an on-chip bit store. Once the whole block is stored, two identical 8-state recursive systematic convolutional encoders run side by side. The first encoder reads the store in natural order. The second reads it in permuted order, with the addresses coming from a quadratic permutation generator.

During encoding, each information bit produces one triplet: the systematic bit, the first parity bit and the second parity bit. The second encoder's copy of the systematic bit is never sent. After the K data triplets, both encoders are driven back to the all-zero state, the first encoder and then the second. The twelve termination bits this yields leave the block as four extra triplets, marked as tail.

The permutation is pi(i) = (F1*i + F2*i^2) mod K. It is produced with modular additions only, so a receiver that knows K, F1 and F2 can reproduce it. Input is refused for the whole time a block is being encoded or emitted.

Top module: `turbo_pc_encoder`

## Requirements
- R1: While reset is held and after it is released, in_ready is 1, out_valid is 0 and out_tail is 0.
- R2: A bit is taken when in_valid and in_ready are both 1. A taken bit with in_sof=1 is stored as block position 0 and restarts any partly loaded block. A bit with in_sof=0 is stored at the next position only if a block has been started. Otherwise it is ignored. The K-th stored bit completes the block.
- R3: Starting one cycle after the bit that completes the block is taken, K data triplets appear on K consecutive cycles with out_valid=1 and out_tail=0. Triplet i carries out_sys = u[i] and out_par1 = the parity of encoder 1 for input u[i]. Each encoder has feedback fb = in ^ D2 ^ D3 and parity = fb ^ D1 ^ D3, where D1 is the newest register stage.
- R4: out_par2 of triplet i is the parity of encoder 2 fed with u[pi(i)], where pi(i) = (F1*i + F2*i*i) mod K. The defaults are K=40, F1=3 and F2=10.
- R5: The last data triplet is followed by 6 cycles with out_valid=0, then 4 triplets with out_valid=1 and out_tail=1. Encoder 1 is terminated over 3 steps and then encoder 2 over 3 steps. At each step the input equals the feedback, the step emits x = D2^D3 and then z = D1^D3, and these pairs form a 12-bit sequence. Tail triplet j carries sequence bits 3j, 3j+1 and 3j+2 on (out_sys, out_par1, out_par2).
- R6: Both encoders begin every block in the all-zero state and are back in the all-zero state when input is accepted again.
- R7: in_ready is 0 from the cycle after the completing bit is taken until the cycle after the last tail triplet. Inputs presented during that time, including in_sof, are ignored and do not change the stored block.
- R8: out_valid and in_ready are never 1 in the same cycle, and out_tail is 1 only when out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit is present |
| in_sof | input | 1 | Input bit is the first bit of a block |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Block accepts input bits |
| out_valid | output | 1 | Output triplet is present |
| out_sys | output | 1 | Systematic bit, or tail sequence bit 3j |
| out_par1 | output | 1 | Encoder 1 parity, or tail sequence bit 3j+1 |
| out_par2 | output | 1 | Encoder 2 parity, or tail sequence bit 3j+2 |
| out_tail | output | 1 | Output triplet is a termination triplet |

## Verification
The bench builds the encoder with its defaults, K=40, F1=3 and F2=10. At that size a block is short enough to sweep a single one through all 40 positions. Each of those runs drives both encoders' impulse responses through every permuted address, and every tail value is worked out from those states. All-zero, all-one, alternating and random blocks are added to the sweep. So are runs that send stray unstarted bits, runs that restart a partly loaded block, and runs that drive junk input while the block is busy. Every triplet is compared with a reference that computes the permutation directly from the quadratic formula.

// File: rtl/turbo_pc_encoder.sv
module turbo_pc_encoder #(
  parameter int K  = 40,
  parameter int F1 = 3,
  parameter int F2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_sys,
  output logic out_par1,
  output logic out_par2,
  output logic out_tail
);
  localparam int AW = (K > 8) ? $clog2(K) : 3;
  localparam logic [AW-1:0] LAST = AW'(K - 1);
  localparam logic [AW:0]   KW   = (AW+1)'(K);
  localparam logic [AW-1:0] G0   = AW'((F1 + F2) % K);
  localparam logic [AW-1:0] DG   = AW'((2 * F2) % K);

  typedef enum logic [1:0] {LOAD, ENC, TERM, TOUT} phase_t;

  phase_t          ph;
  logic [AW-1:0]   cnt, pi_a, g_a, wa;
  logic [K-1:0]    mem;
  logic [2:0]      s1, s2;
  logic [11:0]     tl;
  logic            u1, u2, fb1, fb2, z1, z2, tx, tz, take;

  function automatic logic [AW-1:0] addk(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= KW) s = s - KW;
    return s[AW-1:0];
  endfunction

  assign u1   = mem[cnt];
  assign u2   = mem[pi_a];
  assign fb1  = u1 ^ s1[1] ^ s1[2];
  assign fb2  = u2 ^ s2[1] ^ s2[2];
  assign z1   = fb1 ^ s1[0] ^ s1[2];
  assign z2   = fb2 ^ s2[0] ^ s2[2];
  assign tx   = (cnt < AW'(3)) ? (s1[1] ^ s1[2]) : (s2[1] ^ s2[2]);
  assign tz   = (cnt < AW'(3)) ? (s1[0] ^ s1[2]) : (s2[0] ^ s2[2]);
  assign take = in_valid && in_ready && (in_sof || cnt != '0);
  assign wa   = in_sof ? '0 : cnt;

  assign in_ready  = (ph == LOAD);
  assign out_valid = (ph == ENC) || (ph == TOUT);
  assign out_tail  = (ph == TOUT);
  assign out_sys   = (ph == ENC) ? u1 : (ph == TOUT) && tl[11];
  assign out_par1  = (ph == ENC) ? z1 : (ph == TOUT) && tl[10];
  assign out_par2  = (ph == ENC) ? z2 : (ph == TOUT) && tl[9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= LOAD;
      cnt  <= '0;
      mem  <= '0;
      s1   <= '0;
      s2   <= '0;
      pi_a <= '0;
      g_a  <= G0;
      tl   <= '0;
    end else begin
      case (ph)
        LOAD: begin
          pi_a <= '0;
          g_a  <= G0;
          if (take) begin
            mem[wa] <= in_bit;
            if (wa == LAST) begin
              ph  <= ENC;
              cnt <= '0;
            end else begin
              cnt <= wa + AW'(1);
            end
          end
        end
        ENC: begin
          s1   <= {s1[1:0], fb1};
          s2   <= {s2[1:0], fb2};
          pi_a <= addk(pi_a, g_a);
          g_a  <= addk(g_a, DG);
          if (cnt == LAST) begin
            ph  <= TERM;
            cnt <= '0;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        TERM: begin
          tl <= {tl[9:0], tx, tz};
          if (cnt < AW'(3)) s1 <= {s1[1:0], 1'b0};
          else              s2 <= {s2[1:0], 1'b0};
          if (cnt == AW'(5)) begin
            ph  <= TOUT;
            cnt <= '0;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        default: begin
          tl <= {tl[8:0], 3'b000};
          if (cnt == AW'(3)) begin
            ph  <= LOAD;
            cnt <= '0;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/turbo_pc_encoder_chk.sv
module turbo_pc_encoder_chk #(
  parameter int K = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_tail,
  input logic [K-1:0] wmem,
  input logic [2:0]   st1,
  input logic [2:0]   st2,
  input logic [31:0]  addr
);
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready);
  // R8
  tail_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) out_tail |-> out_valid);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_ready |=> $stable(wmem));
  // R6
  zero_state_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(in_ready) |-> (st1 == 3'b000 && st2 == 3'b000));
  // R5
  ready_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(in_ready) |-> $past(out_tail));
  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) addr < 32'(K));
endmodule

bind turbo_pc_encoder turbo_pc_encoder_chk #(.K(K)) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .in_ready(in_ready),
  .out_valid(out_valid),
  .out_tail(out_tail),
  .wmem(mem),
  .st1(s1),
  .st2(s2),
  .addr(32'(pi_a))
);

// File: tb/sim_turbo_pc_encoder.sv
module sim_turbo_pc_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int K  = 40;
  localparam int F1 = 3;
  localparam int F2 = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_bit = 0;
  logic in_ready, out_valid, out_sys, out_par1, out_par2, out_tail;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  bit blk [K];
  bit e_s [K+4];
  bit e_p1[K+4];
  bit e_p2[K+4];

  always #(CLK_PERIOD/2) clk = ~clk;

  turbo_pc_encoder #(.K(K), .F1(F1), .F2(F2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_sys(out_sys),
    .out_par1(out_par1), .out_par2(out_par2), .out_tail(out_tail));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic build_ref();
    bit [2:0] s;
    bit q[12];
    bit u, fb;
    int n;
    s = 0;
    for (int i = 0; i < K; i++) begin
      u = blk[i];
      fb = u ^ s[1] ^ s[2];
      e_s[i] = u;
      e_p1[i] = fb ^ s[0] ^ s[2];
      s = {s[1:0], fb};
    end
    n = 0;
    for (int t = 0; t < 3; t++) begin
      q[n] = s[1] ^ s[2]; q[n+1] = s[0] ^ s[2]; n += 2;
      s = {s[1:0], 1'b0};
    end
    s = 0;
    for (int i = 0; i < K; i++) begin
      u = blk[(F1*i + F2*i*i) % K];
      fb = u ^ s[1] ^ s[2];
      e_p2[i] = fb ^ s[0] ^ s[2];
      s = {s[1:0], fb};
    end
    for (int t = 0; t < 3; t++) begin
      q[n] = s[1] ^ s[2]; q[n+1] = s[0] ^ s[2]; n += 2;
      s = {s[1:0], 1'b0};
    end
    for (int j = 0; j < 4; j++) begin
      e_s[K+j] = q[3*j]; e_p1[K+j] = q[3*j+1]; e_p2[K+j] = q[3*j+2];
    end
  endtask

  task automatic drive_bit(input bit s, input bit b);
    @(negedge clk);
    in_valid = 1; in_sof = s; in_bit = b;
  endtask

  task automatic run_block(input int garbage, input int partial);
    int idx, cyc, last_d, first_t;
    build_ref();
    for (int g = 0; g < garbage; g++) drive_bit(0, 1'($urandom));
    if (partial > 0) begin
      drive_bit(1, 1'($urandom));
      for (int p = 1; p < partial; p++) drive_bit(0, 1'($urandom));
    end
    for (int i = 0; i < K; i++) drive_bit(i == 0, blk[i]);
    idx = 0; cyc = 0; last_d = -1; first_t = -1;
    while (idx < K + 4 && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk(out_valid == 1, "R3 first triplet latency", int'(out_valid), 1);
        chk(in_ready == 0, "R7 ready low while busy", int'(in_ready), 0);
      end
      chk(!(out_valid && in_ready), "R8 valid/ready exclusive", int'(in_ready), 0);
      if (out_valid) begin
        if (idx < K) begin
          chk(out_tail == 0, "R3 data not tail", int'(out_tail), 0);
          chk(out_sys == e_s[idx], "R3 systematic", int'(out_sys), int'(e_s[idx]));
          chk(out_par1 == e_p1[idx], (idx == 0) ? "R6 parity1 from zero state" : "R3 parity1",
              int'(out_par1), int'(e_p1[idx]));
          chk(out_par2 == e_p2[idx], (idx == 0) ? "R6 parity2 from zero state" : "R4 parity2",
              int'(out_par2), int'(e_p2[idx]));
          last_d = cyc;
        end else begin
          if (first_t < 0) first_t = cyc;
          chk(out_tail == 1, "R5 tail flag", int'(out_tail), 1);
          chk({out_sys, out_par1, out_par2} == {e_s[idx], e_p1[idx], e_p2[idx]}, "R5 tail triplet",
              int'({out_sys, out_par1, out_par2}), int'({e_s[idx], e_p1[idx], e_p2[idx]}));
        end
        idx++;
      end
      if (in_ready) in_valid = 0;
      else begin
        in_valid = 1; in_sof = 1'($urandom); in_bit = 1'($urandom);
      end
    end
    chk(idx == K + 4, "R3 triplet count", idx, K + 4);
    chk(first_t - last_d == 7, "R5 six quiet cycles", first_t - last_d, 7);
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R7 ready after tail", int'({in_ready, out_valid}), 2);
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1 && out_valid == 0 && out_tail == 0, "R1 reset state",
        int'({in_ready, out_valid, out_tail}), 4);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R1 after reset", int'({in_ready, out_valid}), 2);

    for (int i = 0; i < K; i++) blk[i] = 0;
    run_block(0, 0);
    for (int i = 0; i < K; i++) blk[i] = 1;
    run_block(0, 0);
    for (int i = 0; i < K; i++) blk[i] = i[0];
    run_block(0, 0);
    for (int p = 0; p < K; p++) begin
      for (int i = 0; i < K; i++) blk[i] = (i == p);
      run_block(0, 0);
    end
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < K; i++) blk[i] = 1'($urandom);
      run_block(0, 0);
    end
    // R2: stray bits without a start marker, then restarts of partial blocks
    for (int i = 0; i < K; i++) blk[i] = 1'($urandom);
    run_block(5, 0);
    for (int i = 0; i < K; i++) blk[i] = 1'($urandom);
    run_block(0, 13);
    for (int i = 0; i < K; i++) blk[i] = 1'($urandom);
    run_block(3, K - 1);
    finish_run();
  end
endmodule